// File: doc/BRIEF.md
# Chip-Select External Bus Sequencer

This block turns one internal request (a read or write of one, two or four bytes) into cycles on a narrow external memory bus. The 24-bit address goes out on twelve shared pins in two pieces. The upper half is shown first, together with a one-cycle latch pulse, so that an external register can hold it. The lower half then stays on the pins for the rest of the transfer. The top three address bits choose one of eight active-low select lines.

Each select has its own settings byte. The byte holds an enable, the number of wait cycles, how far the strobe start is pushed back, whether the strobe ends one cycle early, and whether the device is one or two bytes wide. When a request is wider than the device, the block splits it into back-to-back transfers, lowest address first. It assembles the read result little-endian and only then raises `done`.

A requester raises `req_valid` for one cycle while `busy` is low. The result appears on `rdata` during the single cycle in which `done` is high.

Top module: `xbc_top`

## Requirements
- R1: After reset, all eight selects, both strobes and `ext_ale` are inactive, and `busy` and `done` are low. Every select starts enabled, with 7 wait cycles, an 8-bit device and no strobe shifting.
- R2: Each transfer starts with exactly one cycle in which `ext_ale` is high, `ext_ad` carries address bits [23:12] and no select is active. The access cycles follow, with `ext_ad` carrying bits [11:0] and exactly one select low: the select numbered by address bits [23:21].
- R3: A transfer holds its select for N = waits+1 cycles. An enabled request keeps `busy` high for beats*(N+1)+1 cycles, and the last of those cycles is the only one in which `done` is high.
- R4: Inside a transfer, cycles are numbered k = 0..N-1. The strobe is active for D <= k < N-E, where D is the delay setting and E is the early-off bit. It is `ext_rd_n` for reads and `ext_wr_n` for writes, the two strobes are never low together, and a strobe is only active while a select is active.
- R5: When N-D-E <= 0, no strobe is produced for that transfer, and the bytes of a read that belong to it come back as zero.
- R6: The number of transfers is the request size divided by the device width, with a minimum of one. Transfers run in ascending address order, and the data lanes are packed little-endian into `rdata` and taken from `req_wdata`.
- R7: A 16-bit device carries even addresses on `ext_din`/`ext_dout` bits [7:0] and odd addresses on bits [15:8]. For a single-byte access to a 16-bit device, only the addressed lane is enabled on `ext_ben_n` (active low, bit 0 is the low lane), and the read byte is returned in `rdata[7:0]`. An 8-bit device always uses bits [7:0].
- R8: A request to a disabled select raises `done` in the next cycle with `rdata` zero. It drives no latch pulse, no select and no strobe.
- R9: Writing `cfg_data` with `cfg_we` high loads the settings of select `cfg_idx`. The fields are: bit 0 enable; bits [3:1] wait cycles; bits [5:4] delay (a value of 3 acts as 2); bit 6 early-off; bit 7 selects a 16-bit device.
- R10: During the access cycles of a write, `ext_doe` is high and `ext_dout` holds that transfer's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_idx | input | 3 | Select whose settings are written |
| cfg_data | input | 8 | Settings byte |
| req_valid | input | 1 | Request pulse, accepted while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 24 | Byte address, aligned to size |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| rdata | output | 32 | Read result, valid with done |
| ext_ad | output | 12 | Multiplexed address pins |
| ext_ale | output | 1 | Upper address latch pulse |
| ext_cs_n | output | 8 | Active-low selects |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_ben_n | output | 2 | Byte lane enables, active low |
| ext_dout | output | 16 | Write data to device |
| ext_doe | output | 1 | Data output enable |
| ext_din | input | 16 | Read data from device |

## Verification
A wrong transfer counter or beat count shows at the ports within the same request. The number of latch pulses, the `busy` length or the number of strobe cycles seen before `done` comes out different. A wrong strobe window changes the strobe cycle count at once, and when the window should be empty it also leaves non-zero read bytes. A wrong lane shift or address offset lands bytes at the wrong memory locations, which a later read-back reveals a few requests later. A wrong settings field changes the timing of the first request that uses that select.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
  localparam int WAIT_W = 3;
  localparam int CNT_W  = WAIT_W + 1;
  localparam int CFG_W  = 8;

  typedef struct packed {
    logic              wide;
    logic              early;
    logic [1:0]        dly;
    logic [WAIT_W-1:0] waits;
    logic              en;
  } xbc_cfg_t;

  localparam xbc_cfg_t CFG_RST = '{wide: 1'b0, early: 1'b0, dly: 2'd0,
                                   waits: {WAIT_W{1'b1}}, en: 1'b1};

  typedef enum logic [1:0] {ST_IDLE, ST_ALE, ST_ACC, ST_DONE} xbc_state_e;
endpackage

// File: rtl/xbc_cfg_bank.sv
module xbc_cfg_bank
  import xbc_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [SEL_W-1:0] idx_i,
  input  logic [CFG_W-1:0] data_i,
  input  logic [SEL_W-1:0] sel_i,
  output xbc_cfg_t         cfg_o
);
  xbc_cfg_t cfg_q [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
    logic hit;
    assign hit = we_i && (idx_i == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= CFG_RST;
      end else if (hit) begin
        cfg_q[g] <= xbc_cfg_t'(data_i);
      end
    end
  end

  assign cfg_o = cfg_q[sel_i];
endmodule

// File: rtl/xbc_strobe_gen.sv
module xbc_strobe_gen
  import xbc_pkg::*;
(
  input  xbc_cfg_t         cfg_i,
  input  logic [CNT_W-1:0] k_i,
  output logic             act_o,
  output logic             last_o
);
  logic [CNT_W-1:0] n_len;
  logic [CNT_W-1:0] start;
  logic [CNT_W-1:0] stop;

  always_comb begin
    n_len  = CNT_W'(cfg_i.waits) + CNT_W'(1);
    start  = (cfg_i.dly == 2'd3) ? CNT_W'(2) : CNT_W'(cfg_i.dly);
    stop   = n_len - CNT_W'(cfg_i.early);
    act_o  = (k_i >= start) && (k_i < stop);
    last_o = act_o && (k_i == stop - CNT_W'(1));
  end
endmodule

// File: rtl/xbc_seq.sv
module xbc_seq
  import xbc_pkg::*;
#(
  parameter int PIN_W  = 12,
  parameter int NUM_CS = 8,
  parameter int DATA_W = 32,
  parameter int BUS_W  = 16,
  localparam int ADDR_W = 2 * PIN_W,
  localparam int SEL_W  = $clog2(NUM_CS),
  localparam int BYTE_W = 8,
  localparam int SH_W   = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_size_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  xbc_cfg_t          cfg_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [CNT_W-1:0]  k_o,
  input  logic              stb_act_i,
  input  logic              stb_last_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PIN_W-1:0]  ad_o,
  output logic              ale_o,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [1:0]        ben_n_o,
  output logic [BUS_W-1:0]  dout_o,
  output logic              doe_o,
  input  logic [BUS_W-1:0]  din_i
);
  xbc_state_e        state_q, state_d;
  logic [1:0]        beat_q, beat_d;
  logic [CNT_W-1:0]  k_q, k_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q;
  logic [1:0]        size_q;
  logic [SEL_W-1:0]  sel_q;

  logic              load;
  logic [1:0]        nlog;
  logic [1:0]        last_beat;
  logic [2:0]        offs;
  logic [ADDR_W-1:0] cur_addr;
  logic              byte_mode;
  logic [SH_W-1:0]   sh;
  logic [BUS_W-1:0]  lane_rd;
  logic [DATA_W-1:0] wpiece;
  logic              in_acc;

  assign load   = (state_q == ST_IDLE) && req_valid_i;
  assign sel_o  = (state_q == ST_IDLE) ? req_addr_i[ADDR_W-1 -: SEL_W] : sel_q;
  assign in_acc = (state_q == ST_ACC);
  assign k_o    = k_q;

  // transfer count and per-transfer address
  always_comb begin
    nlog = (size_q > {1'b0, cfg_i.wide}) ? (size_q - {1'b0, cfg_i.wide}) : 2'd0;
    case (nlog)
      2'd0:    last_beat = 2'd0;
      2'd1:    last_beat = 2'd1;
      default: last_beat = 2'd3;
    endcase
    offs      = cfg_i.wide ? {beat_q, 1'b0} : {1'b0, beat_q};
    cur_addr  = addr_q + ADDR_W'(offs);
    byte_mode = !cfg_i.wide || (size_q == 2'd0);
    sh        = byte_mode ? SH_W'({beat_q, 3'b000}) : SH_W'({beat_q, 4'b0000});
  end

  // data lanes
  always_comb begin
    if (!byte_mode) begin
      lane_rd = din_i;
    end else if (cfg_i.wide && cur_addr[0]) begin
      lane_rd = {{(BUS_W-BYTE_W){1'b0}}, din_i[BUS_W-1 -: BYTE_W]};
    end else begin
      lane_rd = {{(BUS_W-BYTE_W){1'b0}}, din_i[BYTE_W-1:0]};
    end
    wpiece = wdata_q >> sh;
    if (!byte_mode) begin
      dout_o = wpiece[BUS_W-1:0];
    end else if (cfg_i.wide) begin
      dout_o = {wpiece[BYTE_W-1:0], wpiece[BYTE_W-1:0]};
    end else begin
      dout_o = {{(BUS_W-BYTE_W){1'b0}}, wpiece[BYTE_W-1:0]};
    end
  end

  // next state
  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    k_d     = k_q;
    rdata_d = rdata_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          beat_d  = 2'd0;
          k_d     = '0;
          rdata_d = '0;
          state_d = cfg_i.en ? ST_ALE : ST_DONE;
        end
      end
      ST_ALE: begin
        k_d     = '0;
        state_d = ST_ACC;
      end
      ST_ACC: begin
        if (stb_last_i && !write_q) begin
          rdata_d = rdata_q | (DATA_W'(lane_rd) << sh);
        end
        if (k_q == CNT_W'(cfg_i.waits)) begin
          if (beat_q == last_beat) begin
            state_d = ST_DONE;
          end else begin
            beat_d  = beat_q + 2'd1;
            state_d = ST_ALE;
          end
        end else begin
          k_d = k_q + CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      k_q     <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      k_q     <= k_d;
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      size_q  <= '0;
      sel_q   <= '0;
    end else if (load) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      write_q <= req_write_i;
      size_q  <= req_size_i;
      sel_q   <= req_addr_i[ADDR_W-1 -: SEL_W];
    end
  end

  // pins
  always_comb begin
    busy_o  = (state_q != ST_IDLE);
    done_o  = (state_q == ST_DONE);
    rdata_o = rdata_q;
    ale_o   = (state_q == ST_ALE);
    if (state_q == ST_ALE) begin
      ad_o = cur_addr[ADDR_W-1 -: PIN_W];
    end else if (in_acc) begin
      ad_o = cur_addr[PIN_W-1:0];
    end else begin
      ad_o = '0;
    end
    cs_n_o = in_acc ? ~(NUM_CS'(1) << sel_q) : '1;
    rd_n_o = !(in_acc && stb_act_i && !write_q);
    wr_n_o = !(in_acc && stb_act_i && write_q);
    doe_o  = in_acc && write_q;
    if (!in_acc) begin
      ben_n_o = 2'b11;
    end else if (cfg_i.wide && size_q == 2'd0) begin
      ben_n_o = cur_addr[0] ? 2'b01 : 2'b10;
    end else if (cfg_i.wide) begin
      ben_n_o = 2'b00;
    end else begin
      ben_n_o = 2'b10;
    end
  end

  p_disabled_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !cfg_i.en) |=> (done_o && rdata_o == '0));
  p_accept_ale_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cfg_i.en) |=> ale_o);
  p_ale_then_acc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> (!ale_o && in_acc));
endmodule

// File: rtl/xbc_top.sv
module xbc_top
  import xbc_pkg::*;
#(
  parameter int PIN_W  = 12,
  parameter int NUM_CS = 8,
  parameter int DATA_W = 32,
  parameter int BUS_W  = 16,
  localparam int ADDR_W = 2 * PIN_W,
  localparam int SEL_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_idx,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [PIN_W-1:0]  ext_ad,
  output logic              ext_ale,
  output logic [NUM_CS-1:0] ext_cs_n,
  output logic              ext_rd_n,
  output logic              ext_wr_n,
  output logic [1:0]        ext_ben_n,
  output logic [BUS_W-1:0]  ext_dout,
  output logic              ext_doe,
  input  logic [BUS_W-1:0]  ext_din
);
  xbc_cfg_t         cfg;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] kcnt;
  logic             stb_act;
  logic             stb_last;

  xbc_cfg_bank #(.NUM_CS(NUM_CS)) i_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (cfg_we),
    .idx_i  (cfg_idx),
    .data_i (cfg_data),
    .sel_i  (sel),
    .cfg_o  (cfg)
  );

  xbc_strobe_gen i_stb (
    .cfg_i  (cfg),
    .k_i    (kcnt),
    .act_o  (stb_act),
    .last_o (stb_last)
  );

  xbc_seq #(
    .PIN_W (PIN_W),
    .NUM_CS(NUM_CS),
    .DATA_W(DATA_W),
    .BUS_W (BUS_W)
  ) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid),
    .req_write_i (req_write),
    .req_size_i  (req_size),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .cfg_i       (cfg),
    .sel_o       (sel),
    .k_o         (kcnt),
    .stb_act_i   (stb_act),
    .stb_last_i  (stb_last),
    .busy_o      (busy),
    .done_o      (done),
    .rdata_o     (rdata),
    .ad_o        (ext_ad),
    .ale_o       (ext_ale),
    .cs_n_o      (ext_cs_n),
    .rd_n_o      (ext_rd_n),
    .wr_n_o      (ext_wr_n),
    .ben_n_o     (ext_ben_n),
    .dout_o      (ext_dout),
    .doe_o       (ext_doe),
    .din_i       (ext_din)
  );

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));
  p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> !(&ext_cs_n));
  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_cs_n));
  p_ale_no_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ale |-> (&ext_cs_n));
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_doe_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_wr_n |-> ext_doe);
endmodule

// File: tb/test_xbc_top.sv
module test_xbc_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [7:0]  cfg_data;
  logic        req_valid, req_write;
  logic [1:0]  req_size;
  logic [23:0] req_addr;
  logic [31:0] req_wdata;
  logic        busy, done;
  logic [31:0] rdata;
  logic [11:0] ext_ad;
  logic        ext_ale, ext_rd_n, ext_wr_n, ext_doe;
  logic [7:0]  ext_cs_n;
  logic [1:0]  ext_ben_n;
  logic [15:0] ext_dout, ext_din;

  always #(CLK_P/2) clk = ~clk;

  xbc_top i_xbc_top (.*);

  typedef struct {
    bit          wr;
    logic [2:0]  sel;
    int          busy_n;
    int          ale_n;
    int          stb_n;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_fail = 0;

  // bench copy of select settings
  bit   t_en[8], t_wide[8], t_early[8];
  int   t_waits[8], t_dly[8];

  logic [7:0] ref_mem [int];
  logic [7:0] dev_mem [int];
  logic [11:0] dev_hi;

  function automatic logic [7:0] dflt(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'(a >> 16) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] ref_b(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : dflt(a);
  endfunction
  function automatic logic [7:0] dev_b(input int a);
    return dev_mem.exists(a) ? dev_mem[a] : dflt(a);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int idx, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_data = v;
    @(negedge clk);
    cfg_we = 1'b0;
    t_en[idx] = v[0]; t_waits[idx] = int'(v[3:1]); t_dly[idx] = int'(v[5:4]);
    t_early[idx] = v[6]; t_wide[idx] = v[7];
  endtask

  task automatic do_req(input bit wr, input int size, input logic [23:0] a,
                        input logic [31:0] wd, input string tag);
    exp_t e;
    int s, nb, dl, w, bytes;
    s = int'(a[23:21]);
    bytes = 1 << size;
    nb = (size > int'(t_wide[s])) ? (1 << (size - int'(t_wide[s]))) : 1;
    dl = (t_dly[s] == 3) ? 2 : t_dly[s];
    w  = t_waits[s] + 1 - dl - int'(t_early[s]);
    if (w < 0) w = 0;
    e.wr = wr; e.sel = a[23:21]; e.tag = tag; e.data = '0;
    if (!t_en[s]) begin
      e.busy_n = 1; e.ale_n = 0; e.stb_n = 0;
    end else begin
      e.busy_n = nb * (t_waits[s] + 2) + 1;
      e.ale_n  = nb;
      e.stb_n  = nb * w;
      for (int i = 0; i < bytes; i++) begin
        if (wr && w > 0) ref_mem[int'(a) + i] = wd[8*i +: 8];
        if (!wr && w > 0) e.data[8*i +: 8] = ref_b(int'(a) + i);
      end
    end
    sb.push_back(e);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = 2'(size);
    req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  // device model: latches upper address, serves reads, takes writes
  always @(negedge clk) begin
    int a, s;
    if (ext_ale) dev_hi = ext_ad;
    a = int'({dev_hi, ext_ad});
    s = int'(dev_hi[11:9]);
    if (!(&ext_cs_n)) begin
      if (t_wide[s]) ext_din = {dev_b(a | 1), dev_b(a & ~1)};
      else           ext_din = {8'h00, dev_b(a)};
      if (!ext_wr_n) begin
        if (t_wide[s]) begin
          if (!ext_ben_n[0]) dev_mem[a & ~1] = ext_dout[7:0];
          if (!ext_ben_n[1]) dev_mem[a | 1]  = ext_dout[15:8];
        end else begin
          dev_mem[a] = ext_dout[7:0];
        end
      end
    end
  end

  // monitor / scoreboard
  int  m_busy = 0, m_ale = 0, m_stb = 0;
  bit  m_csbad = 0, m_doebad = 0;
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && sb.size() != 0) begin
      e = sb[0];
      if (busy) m_busy++;
      if (ext_ale) m_ale++;
      if (!ext_rd_n || !ext_wr_n) begin
        m_stb++;
        if (ext_cs_n != ~(8'b1 << e.sel)) m_csbad = 1;
        if (!ext_wr_n && !ext_doe) m_doebad = 1;
      end
      if (done) begin
        void'(sb.pop_front());
        chk(m_busy == e.busy_n, "R3", {e.tag, " busy cycles"}, m_busy, e.busy_n);
        chk(m_ale == e.ale_n, "R6", {e.tag, " transfers"}, m_ale, e.ale_n);
        chk(m_stb == e.stb_n, "R4", {e.tag, " strobe cycles"}, m_stb, e.stb_n);
        chk(!m_csbad, "R2", {e.tag, " select during strobe"}, m_csbad, 0);
        chk(!m_doebad, "R10", {e.tag, " output enable"}, m_doebad, 0);
        if (!e.wr) chk(rdata == e.data, "R6", {e.tag, " read data"}, rdata, e.data);
        m_busy = 0; m_ale = 0; m_stb = 0; m_csbad = 0; m_doebad = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      t_en[i] = 1; t_waits[i] = 7; t_dly[i] = 0; t_early[i] = 0; t_wide[i] = 0;
    end
    dev_hi = '0; ext_din = '0;
    rst_n = 1'b0; cfg_we = 0; cfg_idx = 0; cfg_data = 0;
    req_valid = 0; req_write = 0; req_size = 0; req_addr = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ext_cs_n == 8'hFF, "R1", "selects idle", ext_cs_n, 8'hFF);
    chk(ext_rd_n && ext_wr_n, "R1", "strobes idle", {ext_rd_n, ext_wr_n}, 2'b11);
    chk(!ext_ale && !done && !busy, "R1", "ale/done/busy low", {ext_ale, done, busy}, 0);

    // R1 default settings: select 5, 8-bit, 7 waits -> 4 transfers of 8 cycles
    do_req(0, 2, 24'hA0_0010, 0, "R1 default word read");

    // R9 settings: s0 16b 0w; s1 8b 3w d1 e1; s2 16b 1w d2; s3 off; s4 16b 2w e1
    set_cfg(0, 8'h81);
    set_cfg(1, 8'h57);
    set_cfg(2, 8'hA3);
    set_cfg(3, 8'h00);
    set_cfg(4, 8'hC5);

    do_req(1, 2, 24'h00_0100, 32'hDEADBEEF, "R9 R10 word write 16b");
    do_req(0, 2, 24'h00_0100, 0, "R6 word read 16b");
    do_req(1, 1, 24'h20_0202, 32'h0000_1234, "R4 half write shifted 8b");
    do_req(0, 2, 24'h20_0200, 0, "R6 word read 8b");
    do_req(1, 0, 24'h80_0031, 32'h0000_00A5, "R7 odd byte write 16b");
    do_req(1, 0, 24'h80_0032, 32'h0000_003C, "R7 even byte write 16b");
    do_req(0, 2, 24'h80_0030, 0, "R7 word read lanes");
    do_req(0, 0, 24'h80_0031, 0, "R7 odd byte read");
    do_req(0, 1, 24'h80_0032, 0, "R6 half read 16b");
    do_req(0, 2, 24'h40_0000, 0, "R5 suppressed read");
    do_req(1, 2, 24'h40_0004, 32'h11223344, "R5 suppressed write");
    do_req(1, 2, 24'h60_0000, 32'hCAFEF00D, "R8 disabled write");
    do_req(0, 2, 24'h60_0000, 0, "R8 disabled read");
    // R5 suppressed write must leave memory unchanged (read via enabled alias config)
    set_cfg(2, 8'h83);
    do_req(0, 2, 24'h40_0004, 0, "R5 memory untouched");
    @(negedge clk);
    chk(ext_cs_n == 8'hFF && !busy, "R1", "idle after run", {ext_cs_n, busy}, 9'h1FE);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule